// File: doc/BRIEF.md
# Hex Record Stream Loader

This block turns a stream of ASCII text, one character per handshake, into writes on a memory port. The text is a sequence of Intel HEX records, one per line. Each decoded data byte goes out as a one-cycle write strobe, together with a 20-bit address and the byte. The loader also understands end-of-file records and extended segment address records. It keeps three sticky flags: loading finished, checksum error, and malformed record. A host streams a hex image into the loader after reset, then waits for the done flag before releasing the memory to its users.

Segment records set a 16-bit base. The base is multiplied by sixteen and added to the record address and the byte index. Loading stops on an end-of-file record. It also stops on a record header whose byte count and address are both zero. After that, the loader keeps consuming characters but has no effect until it is reset.

Top module: `ihex_loader`

## Requirements
- R1: A line whose first character is not ':' (0x3A) is discarded up to the next CR (0x0D) or LF (0x0A). It causes no write and raises no flag.
- R2: After ':' come the fields in this order: byte count (2 hex digits), record address (4 hex digits), type (2 hex digits), payload, checksum (2 hex digits). Every multi-digit field is sent most significant nibble first.
- R3: If the first digit of the type field is not '0', `bad_record` is set and the rest of the line is discarded with no write.
- R4: In a type 0x00 record, the k-th data byte (high nibble first) is written to ((segment × 16) + record_address + k) modulo 2^20.
- R5: A type 0x01 record sets `load_done` in the cycle after its second type digit is accepted.
- R6: A record whose count and address are both zero sets `load_done` in the same way, whatever its type. A zero-count type 0x00 record with a nonzero address does not.
- R7: A type 0x02 record takes a new segment from its four payload digits. The segment applies to every later data record and is zero after reset.
- R8: The count, address, type, payload and checksum bytes are summed modulo 256. A nonzero sum sets the sticky `csum_error` flag. The record's data writes are still issued.
- R9: `mem_we` is high for a single cycle per byte, with `mem_addr` and `mem_data` valid in that cycle. `in_ready` is low in that cycle.
- R10: A character that is not a hex digit inside a record sets `bad_record` and discards the rest of the line. So does a line terminator that arrives before the checksum is complete.
- R11: Hex digits are accepted in both upper case (A–F) and lower case (a–f).
- R12: Once `load_done` is set, characters are still accepted but cause no write and change no flag.
- R13: A record of type 0x03 to 0x0F is skipped without a write and without a flag. Parsing resumes on the next line.
- R14: A synchronous active-low reset clears the segment, the three flags and the parser state. After reset, `in_ready` is high and `mem_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Character on `in_char` is valid |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Loader accepts a character this cycle |
| mem_we | output | 1 | One-cycle write strobe |
| mem_addr | output | 20 | Write address |
| mem_data | output | 8 | Write data |
| load_done | output | 1 | Sticky: loading has ended |
| csum_error | output | 1 | Sticky: a record checksum did not sum to zero |
| bad_record | output | 1 | Sticky: illegal type, non-hex character or truncated record |

## Verification
Two cases are hard to reach through random text alone. The first is the 20-bit address wrap that comes from a large segment plus a high record address. The second is the distinction between a genuinely empty header and a zero-count record that carries a nonzero address. Directed records target both: segment 0xFFFF with address 0xFFF8, and count zero with address 0x0010. A long random run mixes segment records, data records of 1 to 16 bytes, per-character letter case and idle gaps on `in_valid`. The expected address of every write is rebuilt from the bench's own running segment value.

// File: rtl/ihex_pkg.sv
// Package: shared state encoding and character constants for the hex loader.
// Assumes ASCII input; line terminators are CR and LF.
package ihex_pkg;

    typedef enum logic [3:0] {
        ST_LINE,   // waiting for start of a record
        ST_SKIP,   // discarding until a line terminator
        ST_COUNT,  // byte count field
        ST_ADDR,   // record address field
        ST_TYPE,   // record type field
        ST_DATA,   // data bytes of a type 0 record
        ST_SEG,    // segment value of a type 2 record
        ST_CSUM,   // checksum field
        ST_TAIL,   // after checksum, waiting for terminator
        ST_DONE    // loading finished
    } parse_st_t;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

endpackage

// File: rtl/ihex_hex_decode.sv
// Module: ihex_hex_decode
// Converts one ASCII character to a 4-bit value and flags whether it is a
// hex digit. Upper and lower case letters are both accepted.
// Assumes: purely combinational, no state.
module ihex_hex_decode (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib
);

    // Classify the character and derive its nibble value
    always_comb begin
        is_hex = 1'b0;
        nib    = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            nib    = ch[3:0];
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            is_hex = 1'b1;
            nib    = ch[3:0] + 4'd9;
        end
    end

endmodule

// File: rtl/ihex_csum_acc.sv
// Module: ihex_csum_acc
// Running modulo-2^W sum of the bytes of one record.
// Assumes: clear and add are never asserted in the same cycle.
module ihex_csum_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         add,
    input  logic [W-1:0] byte_in,
    output logic [W-1:0] sum
);

    // Accumulate record bytes; restart at each record start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clear) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + byte_in;
        end
    end

endmodule

// File: rtl/ihex_addr_gen.sv
// Module: ihex_addr_gen
// Holds the segment base and the running write address. On start the
// address becomes (segment << SEG_SHIFT) + record address; on step it
// advances by one, wrapping at 2^ADDR_W.
// Assumes: start and step are never high together.
module ihex_addr_gen #(
    parameter int ADDR_W    = 20,
    parameter int SEG_W     = 16,
    parameter int REC_AW    = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_load,
    input  logic [SEG_W-1:0]  seg_val,
    input  logic              start,
    input  logic [REC_AW-1:0] rec_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    logic [SEG_W-1:0]  seg_q;
    logic [ADDR_W-1:0] base;

    // Form the record base address from segment and record address
    always_comb begin
        base = (ADDR_W'(seg_q) << SEG_SHIFT) + ADDR_W'(rec_addr);
    end

    // Segment register, zero after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else if (seg_load) begin
            seg_q <= seg_val;
        end
    end

    // Running write address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (start) begin
            addr <= base;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    // Each write moves the address on by exactly one (R4)
    p_step_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/ihex_loader.sv
// Module: ihex_loader
// Parses a character stream of hex records and issues one memory write per
// data byte. Handles data, end-of-file and segment records; flags checksum
// and format errors; stops after end of data until reset.
// Assumes: ASCII input, one character per valid/ready handshake.
module ihex_loader #(
    parameter int ADDR_W    = 20,
    parameter int SEG_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              load_done,
    output logic              csum_error,
    output logic              bad_record
);
    import ihex_pkg::*;

    localparam int SEG_W  = 16;
    localparam int REC_AW = 16;
    localparam int FCNT_W = $clog2(REC_AW / 4) + 1;
    localparam logic [FCNT_W-1:0] LAST_ADDR_NIB = FCNT_W'(REC_AW / 4 - 1);
    localparam logic [FCNT_W-1:0] LAST_SEG_NIB  = FCNT_W'(SEG_W / 4 - 1);

    parse_st_t          st_q;
    logic [FCNT_W-1:0]  fcnt_q;
    logic [3:0]         hi_q;
    logic [7:0]         cnt_q;
    logic [REC_AW-1:0]  raddr_q;
    logic [SEG_W-1:0]   seg_sh_q;
    logic [7:0]         left_q;
    logic               we_q;
    logic [7:0]         wdata_q;
    logic               done_q;
    logic               cerr_q;
    logic               ill_q;

    logic               acc;
    logic               is_term;
    logic               dec_ok;
    logic [3:0]         nib;
    logic [7:0]         cur_byte;
    logic               second_nib;
    logic               in_rec;
    logic               hex_step;
    logic               zero_hdr;
    logic               csum_clr;
    logic               csum_add;
    logic [7:0]         csum_sum;
    logic               seg_ld;
    logic [SEG_W-1:0]   seg_val;
    logic               a_start;

    ihex_hex_decode u_dec (
        .ch     (in_char),
        .is_hex (dec_ok),
        .nib    (nib)
    );

    ihex_csum_acc #(.W(8)) u_csum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (csum_clr),
        .add     (csum_add),
        .byte_in (cur_byte),
        .sum     (csum_sum)
    );

    ihex_addr_gen #(
        .ADDR_W    (ADDR_W),
        .SEG_W     (SEG_W),
        .REC_AW    (REC_AW),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .seg_load (seg_ld),
        .seg_val  (seg_val),
        .start    (a_start),
        .rec_addr (raddr_q),
        .step     (we_q),
        .addr     (mem_addr)
    );

    // Handshake and per-character decode of the current parser context
    always_comb begin
        in_ready   = !we_q;
        acc        = in_valid && in_ready;
        is_term    = (in_char == CH_CR) || (in_char == CH_LF);
        cur_byte   = {hi_q, nib};
        second_nib = fcnt_q[0];
        in_rec     = (st_q == ST_COUNT) || (st_q == ST_ADDR) || (st_q == ST_TYPE) ||
                     (st_q == ST_DATA)  || (st_q == ST_SEG)  || (st_q == ST_CSUM);
        hex_step   = acc && in_rec && !is_term && dec_ok;
        zero_hdr   = (cnt_q == 8'h00) && (raddr_q == '0);
        csum_clr   = acc && (st_q == ST_LINE) && (in_char == CH_COLON);
        csum_add   = hex_step && second_nib && (st_q != ST_CSUM);
        seg_val    = {seg_sh_q[SEG_W-5:0], nib};
        seg_ld     = hex_step && (st_q == ST_SEG) && (fcnt_q == LAST_SEG_NIB);
        a_start    = hex_step && (st_q == ST_TYPE) && second_nib &&
                     (nib == 4'h0) && !zero_hdr;
    end

    // Record parser: field sequencing, write issue and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_LINE;
            fcnt_q   <= '0;
            hi_q     <= '0;
            cnt_q    <= '0;
            raddr_q  <= '0;
            seg_sh_q <= '0;
            left_q   <= '0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
            done_q   <= 1'b0;
            cerr_q   <= 1'b0;
            ill_q    <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (acc) begin
                case (st_q)
                    ST_LINE: begin
                        if (in_char == CH_COLON) begin
                            st_q   <= ST_COUNT;
                            fcnt_q <= '0;
                        end else if (!is_term) begin
                            st_q <= ST_SKIP;
                        end
                    end
                    ST_SKIP, ST_TAIL: begin
                        if (is_term) begin
                            st_q <= ST_LINE;
                        end
                    end
                    ST_DONE: begin
                        st_q <= ST_DONE;
                    end
                    default: begin
                        if (is_term) begin
                            ill_q <= 1'b1;
                            st_q  <= ST_LINE;
                        end else if (!dec_ok) begin
                            ill_q <= 1'b1;
                            st_q  <= ST_SKIP;
                        end else begin
                            hi_q   <= nib;
                            fcnt_q <= fcnt_q + 1'b1;
                            case (st_q)
                                ST_COUNT: begin
                                    if (second_nib) begin
                                        cnt_q  <= cur_byte;
                                        st_q   <= ST_ADDR;
                                        fcnt_q <= '0;
                                    end
                                end
                                ST_ADDR: begin
                                    raddr_q <= {raddr_q[REC_AW-5:0], nib};
                                    if (fcnt_q == LAST_ADDR_NIB) begin
                                        st_q   <= ST_TYPE;
                                        fcnt_q <= '0;
                                    end
                                end
                                ST_TYPE: begin
                                    if (!second_nib) begin
                                        if (nib != 4'h0) begin
                                            ill_q <= 1'b1;
                                            st_q  <= ST_SKIP;
                                        end
                                    end else begin
                                        fcnt_q <= '0;
                                        if (zero_hdr || nib == 4'h1) begin
                                            done_q <= 1'b1;
                                            st_q   <= ST_DONE;
                                        end else if (nib == 4'h0) begin
                                            left_q <= cnt_q;
                                            st_q   <= (cnt_q == 8'h00) ? ST_CSUM : ST_DATA;
                                        end else if (nib == 4'h2) begin
                                            st_q <= ST_SEG;
                                        end else begin
                                            st_q <= ST_SKIP;
                                        end
                                    end
                                end
                                ST_DATA: begin
                                    if (second_nib) begin
                                        we_q    <= 1'b1;
                                        wdata_q <= cur_byte;
                                        left_q  <= left_q - 1'b1;
                                        fcnt_q  <= '0;
                                        if (left_q == 8'h01) begin
                                            st_q <= ST_CSUM;
                                        end
                                    end
                                end
                                ST_SEG: begin
                                    seg_sh_q <= seg_val;
                                    if (fcnt_q == LAST_SEG_NIB) begin
                                        st_q   <= ST_CSUM;
                                        fcnt_q <= '0;
                                    end
                                end
                                ST_CSUM: begin
                                    if (second_nib) begin
                                        if ((csum_sum + cur_byte) != 8'h00) begin
                                            cerr_q <= 1'b1;
                                        end
                                        st_q <= ST_TAIL;
                                    end
                                end
                                default: begin
                                    st_q <= ST_SKIP;
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    // Output mapping
    always_comb begin
        mem_we     = we_q;
        mem_data   = wdata_q;
        load_done  = done_q;
        csum_error = cerr_q;
        bad_record = ill_q;
    end

    // Write strobe lasts one cycle (R9)
    p_we_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // Done flag holds until reset (R5)
    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    // Checksum error flag holds until reset (R8)
    p_csum_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        csum_error |=> csum_error);

    // Malformed-record flag holds until reset (R10)
    p_bad_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_record |=> bad_record);

    // No writes once loading has ended (R12)
    p_no_write_after_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !mem_we);

endmodule

// File: tb/ihex_loader_tb_top.sv
// Bench: directed corner records plus a seeded random record stream,
// compared against write lists built by the bench itself.
module ihex_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        in_ready;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_data;
    logic        load_done;
    logic        csum_error;
    logic        bad_record;

    int n_chk = 0;
    int n_bad = 0;

    logic [19:0] exp_a[$];
    logic [7:0]  exp_d[$];
    logic [19:0] got_a[$];
    logic [7:0]  got_d[$];
    logic [7:0]  pay[$];
    logic [15:0] bseg = 16'h0000;
    logic [7:0]  run_sum = 8'h00;
    int          case_mode = 0;
    int          gap_max = 0;

    always #4 clk = ~clk;

    ihex_loader dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_char    (in_char),
        .in_ready   (in_ready),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .load_done  (load_done),
        .csum_error (csum_error),
        .bad_record (bad_record)
    );

    function automatic void check(input bit ok, input string req,
                                  input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endfunction

    // Capture writes; R9: ready must be low while a write is out
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            got_a.push_back(mem_addr);
            got_d.push_back(mem_data);
            check(in_ready == 1'b0, "R9 ready during write", in_ready, 0);
        end
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic logic [7:0] hexc(input logic [3:0] n);
        bit low;
        low = (case_mode == 1) || (case_mode == 2 && ($urandom % 2) == 1);
        if (n < 10) return 8'h30 + 8'(n);
        return (low ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
    endfunction

    task automatic send_char(input logic [7:0] c);
        if (gap_max > 0) repeat ($urandom % (gap_max + 1)) @(negedge clk);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_char  = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        run_sum = run_sum + b;
        send_char(hexc(b[7:4]));
        send_char(hexc(b[3:0]));
    endtask

    task automatic send_eol();
        send_char(8'h0D);
        send_char(8'h0A);
    endtask

    task automatic send_csum(input bit bad);
        logic [7:0] c;
        c = 8'h00 - run_sum;
        if (bad) c = c ^ 8'h5A;
        send_char(hexc(c[7:4]));
        send_char(hexc(c[3:0]));
    endtask

    // Data record from pay[]; expected writes use the bench segment
    task automatic emit_data(input logic [15:0] a, input bit bad);
        int n;
        n = pay.size();
        run_sum = 8'h00;
        send_char(8'h3A);
        send_byte(8'(n));
        send_byte(a[15:8]);
        send_byte(a[7:0]);
        send_byte(8'h00);
        for (int k = 0; k < n; k++) begin
            exp_a.push_back(({4'h0, bseg} << 4) + {4'h0, a} + 20'(k));
            exp_d.push_back(pay[k]);
            send_byte(pay[k]);
        end
        send_csum(bad);
        send_eol();
        pay.delete();
    endtask

    task automatic emit_seg(input logic [15:0] s);
        run_sum = 8'h00;
        send_char(8'h3A);
        send_byte(8'h02);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h02);
        send_byte(s[15:8]);
        send_byte(s[7:0]);
        send_csum(1'b0);
        send_eol();
        bseg = s;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
    endtask

    task automatic compare_writes(input string req);
        repeat (3) @(negedge clk);
        check(got_a.size() == exp_a.size(), req, got_a.size(), exp_a.size());
        for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
            check(got_a[i] == exp_a[i], req, got_a[i], exp_a[i]);
            check(got_d[i] == exp_d[i], req, got_d[i], exp_d[i]);
        end
        got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bseg = 16'h0000;
        got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        do_reset();

        // R14: state after reset
        check(in_ready == 1'b1, "R14 ready", in_ready, 1);
        check(mem_we == 1'b0, "R14 we", mem_we, 0);
        check({load_done, csum_error, bad_record} == 3'b000, "R14 flags",
              {load_done, csum_error, bad_record}, 0);

        // R2 R4: directed data record, upper case
        case_mode = 0;
        pay.push_back(8'hA0); pay.push_back(8'h0B); pay.push_back(8'hC7);
        emit_data(16'h1234, 1'b0);
        compare_writes("R2 R4 directed data");
        check(csum_error == 1'b0, "R8 good csum", csum_error, 0);

        // R11: lower case digits
        case_mode = 1;
        pay.push_back(8'hFE); pay.push_back(8'hDC);
        emit_data(16'hABCD, 1'b0);
        compare_writes("R11 lower case");
        case_mode = 0;

        // R1: line not starting with ':' is skipped, even with a record in it
        send_str("#:02000000AABB99");
        send_eol();
        compare_writes("R1 skipped line");
        check(bad_record == 1'b0, "R1 no flag", bad_record, 0);

        // R13: type 3 record ignored, next data still works
        send_str(":0400000300001234B3");
        send_eol();
        pay.push_back(8'h55);
        emit_data(16'h0020, 1'b0);
        compare_writes("R13 unsupported type");
        check({csum_error, bad_record} == 2'b00, "R13 no flag",
              {csum_error, bad_record}, 0);

        // R6: zero count with nonzero address is not an end
        send_str(":00001000F0");
        send_eol();
        check(load_done == 1'b0, "R6 nonzero addr no done", load_done, 0);
        compare_writes("R6 zero count no write");

        // R7: segment record applies to later data, incl 20-bit wrap
        emit_seg(16'h1234);
        pay.push_back(8'h11); pay.push_back(8'h22); pay.push_back(8'h33);
        emit_data(16'hFFF0, 1'b0);
        emit_seg(16'hFFFF);
        pay.push_back(8'h44); pay.push_back(8'h66);
        emit_data(16'hFFF8, 1'b0);
        compare_writes("R7 R4 segment and wrap");

        // R8: bad checksum flags but writes still issued
        pay.push_back(8'h9A); pay.push_back(8'h01);
        emit_data(16'h0300, 1'b1);
        compare_writes("R8 writes kept");
        check(csum_error == 1'b1, "R8 csum flag", csum_error, 1);

        // R3: upper type digit nonzero
        do_reset();
        send_str(":01000010AA45");
        send_eol();
        compare_writes("R3 no write");
        check(bad_record == 1'b1, "R3 flag", bad_record, 1);

        // R10: non-hex character in address field
        do_reset();
        send_str(":0200G0000102FB");
        send_eol();
        compare_writes("R10 non-hex no write");
        check(bad_record == 1'b1, "R10 non-hex flag", bad_record, 1);

        // R10: terminator before checksum
        do_reset();
        send_str(":0200");
        send_eol();
        check(bad_record == 1'b1, "R10 truncated flag", bad_record, 1);
        check(load_done == 1'b0, "R10 not done", load_done, 0);

        // R6: all-zero header ends loading
        do_reset();
        send_str(":0000000000");
        send_eol();
        check(load_done == 1'b1, "R6 zero header done", load_done, 1);

        // R5 R12: end-of-file record, then input has no effect
        do_reset();
        send_str(":00000001FF");
        send_eol();
        check(load_done == 1'b1, "R5 eof done", load_done, 1);
        send_str(":0100100077");
        send_str(":0G");
        send_eol();
        repeat (3) @(negedge clk);
        check(got_a.size() == 0, "R12 no write after done", got_a.size(), 0);
        check({csum_error, bad_record} == 2'b00, "R12 flags unchanged",
              {csum_error, bad_record}, 0);
        check(in_ready == 1'b1, "R12 still accepting", in_ready, 1);

        // Random stream: R4 R7 R11 with gaps and mixed case
        do_reset();
        case_mode = 2;
        gap_max = 2;
        for (int r = 0; r < 40; r++) begin
            if ($urandom % 5 == 0) begin
                emit_seg(16'($urandom));
            end else begin
                logic [15:0] a;
                int n;
                n = 1 + ($urandom % 16);
                a = 16'($urandom);
                for (int k = 0; k < n; k++) pay.push_back(8'($urandom));
                emit_data(a, 1'b0);
            end
        end
        send_str(":00000001FF");
        send_eol();
        compare_writes("R4 R7 R11 random");
        check(load_done == 1'b1, "R5 random done", load_done, 1);
        check({csum_error, bad_record} == 2'b00, "R8 R10 random clean",
              {csum_error, bad_record}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule